// File: doc/BRIEF.md
# Call, Return and Interrupt Stack Sequencer

This block is the multi-cycle stack engine beside an 8-bit processor core. The core samples one command on `start` with a 4-bit operation code, the current program counter, a 16-bit target and the current status byte. The block then runs byte writes or byte reads on a synchronous, byte-wide memory port, always inside the stack page. It keeps the 8-bit stack pointer and, on a one-cycle `done` pulse, presents the new program counter, status, accumulator and X values.

The stack pointer indexes page 0x01. A push writes at 0x0100+SP and then lowers SP by one. A pull raises SP by one and then reads at the new 0x0100+SP. SP wraps modulo 256 and has no overflow detection. Sixteen-bit values go onto the stack high byte first, so the low byte comes back first. The memory returns read data one cycle after `mem_re`. `done` rises in the cycle after the last write, or in the second cycle after the last read.

Operation codes: 0 call, 1 return, 2 break, 3 interrupt return, 4 push accumulator, 5 pull accumulator, 6 push status, 7 pull status, 8 X to SP, 9 SP to X. Codes 10 to 15 do nothing. Status bit 7 is N and bit 1 is Z. Bits 5 and 4 are the two fixed bits: they are forced to 1 when status is pushed and are not changed by a pull.

Top module: `stack_seq`

## Requirements
- R1: Call (op 0) writes the high byte of pc_in+2 at 0x0100+SP and then its low byte at 0x0100+SP-1, leaves SP lower by 2, and sets pc_out to target_in and status_out to status_in.
- R2: Return (op 1) reads the low byte at 0x0100+SP+1 and the high byte at 0x0100+SP+2, leaves SP higher by 2, and sets pc_out to the pulled value plus 1.
- R3: Break (op 2) writes the high byte of pc_in+2, then its low byte, then status_in with bits 5 and 4 set, on three descending addresses. It leaves SP lower by 3, sets pc_out to target_in and leaves status_out equal to status_in.
- R4: Interrupt return (op 3) pulls status first, then the PC low byte, then the high byte. It sets pc_out to the pulled PC with no increment, and sets status_out to the pulled byte except bits 5 and 4, which are taken from status_in.
- R5: Push accumulator (op 4) writes acc_in and push status (op 6) writes status_in OR 0x30. Each makes one write, lowers SP by 1, and leaves status_out equal to status_in.
- R6: Pull accumulator (op 5) sets acc_out to the pulled byte and sets status_out to status_in with bit 7 equal to byte bit 7 and bit 1 set exactly when the byte is zero.
- R7: Pull status (op 7) sets status_out to the pulled byte with bits 5 and 4 replaced by those of status_in, and raises SP by 1.
- R8: X to SP (op 8) loads SP from x_in with no memory access and no status change. SP to X (op 9) sets x_out to SP and updates bits 7 and 1 of status_out from that value.
- R9: SP wraps modulo 256: a push at SP 0x00 writes 0x0100 and leaves 0xFF, and a pull at SP 0xFF reads 0x0100 and leaves 0x00.
- R10: After reset SP is 0xFF, and done, busy and all result outputs are 0. Counting the start cycle as 0, done is a single-cycle pulse in cycle 3 for call, 4 for return and break, 5 for interrupt return, 3 for the pulls, and 2 for the pushes and register moves.
- R11: start is ignored while busy is high; a command then held on start causes no extra memory access or SP change.
- R12: mem_we and mem_re are never high together, every access addresses page 0x01, and no access occurs while busy is low.
- R13: Codes 10 to 15 finish in 2 cycles with no memory access and no SP change, with pc_out equal to pc_in and status_out equal to status_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted while idle |
| op | input | 4 | Operation code |
| pc_in | input | 16 | Current program counter |
| target_in | input | 16 | Jump target or break vector |
| status_in | input | 8 | Current status byte |
| acc_in | input | 8 | Accumulator value to push |
| x_in | input | 8 | X value for the SP load |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe, data valid next cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| status_out | output | 8 | Resulting status byte |
| acc_out | output | 8 | Accumulator from the last pull |
| x_out | output | 8 | X from the last SP-to-X move |

## Verification
The bench targets the return-offset asymmetry: call then return must give pc_in+3, and break then interrupt return must give pc_in+2. A design that adds the increment in the wrong operation ends up one byte off. It drives SP across both wrap points, where a design that pulls before incrementing, or pushes after decrementing, reads or writes the wrong stack byte and breaks the memory comparison. It pulls zero and negative bytes, to catch wrong N/Z updates or a disturbed fixed bit 5 or 4. It holds start high through a busy command, so a design that re-arms early shows an extra push as a wrong SP. Long random runs compare every stack byte, and the done latency, against a bench model.

// File: rtl/stack_seq_pkg.sv
// Shared types for the stack sequencer.
// Holds the operation codes, the per-step micro action record and the
// status-bit helpers. Assumes 8-bit data and a 16-bit program counter.
package stack_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;
    localparam int OP_W   = 4;
    localparam int STEP_W = 2;

    localparam logic [OP_W-1:0] OP_CALL  = 4'd0;
    localparam logic [OP_W-1:0] OP_RET   = 4'd1;
    localparam logic [OP_W-1:0] OP_BRK   = 4'd2;
    localparam logic [OP_W-1:0] OP_RTI   = 4'd3;
    localparam logic [OP_W-1:0] OP_PUSHA = 4'd4;
    localparam logic [OP_W-1:0] OP_PULLA = 4'd5;
    localparam logic [OP_W-1:0] OP_PUSHS = 4'd6;
    localparam logic [OP_W-1:0] OP_PULLS = 4'd7;
    localparam logic [OP_W-1:0] OP_TXS   = 4'd8;
    localparam logic [OP_W-1:0] OP_TSX   = 4'd9;

    localparam int FLAG_N = 7;
    localparam int FLAG_Z = 1;
    localparam logic [BYTE_W-1:0] FIXED_MASK = 8'h30;

    typedef enum logic [1:0] {ACT_NONE, ACT_WR, ACT_RD} act_e;
    typedef enum logic [1:0] {SRC_RET_HI, SRC_RET_LO, SRC_STAT, SRC_ACC} src_e;
    typedef enum logic [1:0] {DST_PCL, DST_PCH, DST_STAT, DST_ACC} dst_e;

    typedef struct packed {
        act_e act;
        src_e src;
        dst_e dst;
        logic last;
    } step_t;

    // Update N and Z in a status image from a data value.
    function automatic logic [BYTE_W-1:0] with_nz(input logic [BYTE_W-1:0] st,
                                                  input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        r         = st;
        r[FLAG_N] = v[BYTE_W-1];
        r[FLAG_Z] = (v == '0);
        return r;
    endfunction

    // Merge a pulled status byte, keeping the fixed bits of the current one.
    function automatic logic [BYTE_W-1:0] keep_fixed(input logic [BYTE_W-1:0] pulled,
                                                     input logic [BYTE_W-1:0] cur);
        return (pulled & ~FIXED_MASK) | (cur & FIXED_MASK);
    endfunction

endpackage

// File: rtl/stack_seq_plan.sv
// Step table of the stack sequencer.
// Maps (operation, step index) to one memory action per cycle: what to
// write, where read data goes, and whether this step is the final one.
// Assumes the step index never passes the last step of the operation.
module stack_seq_plan
    import stack_seq_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [STEP_W-1:0] step,
    output step_t             cur
);

    // Purpose: decode the action for the current step.
    always_comb begin
        cur = '{act: ACT_NONE, src: SRC_RET_HI, dst: DST_PCL, last: 1'b1};
        case (op)
            OP_CALL: begin
                cur.act  = ACT_WR;
                cur.src  = (step == 2'd0) ? SRC_RET_HI : SRC_RET_LO;
                cur.last = (step == 2'd1);
            end
            OP_RET: begin
                cur.act  = ACT_RD;
                cur.dst  = (step == 2'd0) ? DST_PCL : DST_PCH;
                cur.last = (step == 2'd1);
            end
            OP_BRK: begin
                cur.act  = ACT_WR;
                case (step)
                    2'd0:    cur.src = SRC_RET_HI;
                    2'd1:    cur.src = SRC_RET_LO;
                    default: cur.src = SRC_STAT;
                endcase
                cur.last = (step == 2'd2);
            end
            OP_RTI: begin
                cur.act  = ACT_RD;
                case (step)
                    2'd0:    cur.dst = DST_STAT;
                    2'd1:    cur.dst = DST_PCL;
                    default: cur.dst = DST_PCH;
                endcase
                cur.last = (step == 2'd2);
            end
            OP_PUSHA: begin
                cur.act = ACT_WR;
                cur.src = SRC_ACC;
            end
            OP_PULLA: begin
                cur.act = ACT_RD;
                cur.dst = DST_ACC;
            end
            OP_PUSHS: begin
                cur.act = ACT_WR;
                cur.src = SRC_STAT;
            end
            OP_PULLS: begin
                cur.act = ACT_RD;
                cur.dst = DST_STAT;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stack_seq_ptr.sv
// Stack pointer register.
// Holds SP, moves it by one on a push or a pull, or loads it outright.
// Also gives SP+1, the pull address index. Wraps modulo 256 by width.
module stack_seq_ptr
    import stack_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SP_INIT = 8'hFF
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pull,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] sp,
    output logic [BYTE_W-1:0] sp_up
);

    assign sp_up = sp + 8'd1;

    // Purpose: update SP; a load wins over a push or a pull.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= SP_INIT;
        else if (load) sp <= load_val;
        else if (push) sp <= sp - 8'd1;
        else if (pull) sp <= sp_up;
    end

endmodule

// File: rtl/stack_seq_result.sv
// Result assembly for the stack sequencer.
// Captures returning read bytes into scratch registers and, on commit,
// forms pc_out, status_out, acc_out and x_out for the finished command.
// The byte arriving in the commit cycle is taken straight from rdata.
module stack_seq_result
    import stack_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  dst_e              cap_dst,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              commit,
    input  logic [OP_W-1:0]   op,
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   target,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] sp_now,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] status_out,
    output logic [BYTE_W-1:0] acc_out,
    output logic [BYTE_W-1:0] x_out
);

    logic [BYTE_W-1:0] pcl_q, pch_q, st_q, acc_q;
    logic [BYTE_W-1:0] m_pcl, m_pch, m_st, m_acc;
    logic [PC_W-1:0]   pulled_pc;

    // Purpose: latch each returning byte into its scratch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcl_q <= '0;
            pch_q <= '0;
            st_q  <= '0;
            acc_q <= '0;
        end else if (cap_en) begin
            case (cap_dst)
                DST_PCL:  pcl_q <= rdata;
                DST_PCH:  pch_q <= rdata;
                DST_STAT: st_q  <= rdata;
                default:  acc_q <= rdata;
            endcase
        end
    end

    // Purpose: view the scratch bytes with the byte arriving this cycle.
    always_comb begin
        m_pcl = (cap_en && cap_dst == DST_PCL)  ? rdata : pcl_q;
        m_pch = (cap_en && cap_dst == DST_PCH)  ? rdata : pch_q;
        m_st  = (cap_en && cap_dst == DST_STAT) ? rdata : st_q;
        m_acc = (cap_en && cap_dst == DST_ACC)  ? rdata : acc_q;
        pulled_pc = {m_pch, m_pcl};
    end

    // Purpose: form the visible results when a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out     <= '0;
            status_out <= '0;
            acc_out    <= '0;
            x_out      <= '0;
        end else if (commit) begin
            case (op)
                OP_CALL, OP_BRK: begin
                    pc_out     <= target;
                    status_out <= status;
                end
                OP_RET: begin
                    pc_out     <= pulled_pc + 16'd1;
                    status_out <= status;
                end
                OP_RTI: begin
                    pc_out     <= pulled_pc;
                    status_out <= keep_fixed(m_st, status);
                end
                OP_PULLA: begin
                    pc_out     <= pc;
                    acc_out    <= m_acc;
                    status_out <= with_nz(status, m_acc);
                end
                OP_PULLS: begin
                    pc_out     <= pc;
                    status_out <= keep_fixed(m_st, status);
                end
                OP_TSX: begin
                    pc_out     <= pc;
                    x_out      <= sp_now;
                    status_out <= with_nz(status, sp_now);
                end
                default: begin
                    pc_out     <= pc;
                    status_out <= status;
                end
            endcase
        end
    end

endmodule

// File: rtl/stack_seq.sv
// Call, return and interrupt stack sequencer (top).
// Accepts one command while idle, walks its step table one memory access
// per cycle, waits one extra cycle after a final read for the data, then
// commits results and pulses done. Assumes a synchronous byte memory
// with one cycle of read latency; start is ignored while busy.
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE    = 8'h01,
    parameter logic [BYTE_W-1:0] SP_INIT = 8'hFF
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   target_in,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] x_in,
    output logic [PC_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] sp,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] status_out,
    output logic [BYTE_W-1:0] acc_out,
    output logic [BYTE_W-1:0] x_out
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_FIN} state_e;

    state_e            state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [OP_W-1:0]   op_q;
    logic [PC_W-1:0]   pc_q, ret_q, tgt_q;
    logic [BYTE_W-1:0] st_q, acc_q, x_q;
    logic              rd_pend_q;
    dst_e              rd_dst_q;
    step_t             cur;
    logic [BYTE_W-1:0] sp_up;
    logic              run, do_wr, do_rd, do_load, commit;

    stack_seq_plan u_plan (
        .op   (op_q),
        .step (step_q),
        .cur  (cur)
    );

    assign run     = (state_q == S_RUN);
    assign do_wr   = run && (cur.act == ACT_WR);
    assign do_rd   = run && (cur.act == ACT_RD);
    assign do_load = run && (op_q == OP_TXS);
    assign commit  = (run && cur.last && cur.act != ACT_RD) || (state_q == S_DRAIN);

    stack_seq_ptr #(.SP_INIT(SP_INIT)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_wr),
        .pull     (do_rd),
        .load     (do_load),
        .load_val (x_q),
        .sp       (sp),
        .sp_up    (sp_up)
    );

    stack_seq_result u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (rd_pend_q),
        .cap_dst    (rd_dst_q),
        .rdata      (mem_rdata),
        .commit     (commit),
        .op         (op_q),
        .pc         (pc_q),
        .target     (tgt_q),
        .status     (st_q),
        .sp_now     (sp),
        .pc_out     (pc_out),
        .status_out (status_out),
        .acc_out    (acc_out),
        .x_out      (x_out)
    );

    // Purpose: next-state decode of the command sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (cur.last) state_d = (cur.act == ACT_RD) ? S_DRAIN : S_FIN;
            S_DRAIN: state_d = S_FIN;
            default: state_d = S_IDLE;
        endcase
    end

    // Purpose: state, step counter and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            op_q    <= '0;
            pc_q    <= '0;
            ret_q   <= '0;
            tgt_q   <= '0;
            st_q    <= '0;
            acc_q   <= '0;
            x_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                step_q <= '0;
                op_q   <= op;
                pc_q   <= pc_in;
                ret_q  <= pc_in + 16'd2;
                tgt_q  <= target_in;
                st_q   <= status_in;
                acc_q  <= acc_in;
                x_q    <= x_in;
            end else if (run && !cur.last) begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    // Purpose: remember where the byte returning next cycle belongs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_dst_q  <= DST_PCL;
        end else begin
            rd_pend_q <= do_rd;
            rd_dst_q  <= cur.dst;
        end
    end

    // Purpose: drive the stack memory port for the current step.
    always_comb begin
        mem_we   = do_wr;
        mem_re   = do_rd;
        mem_addr = {PAGE, (do_rd ? sp_up : sp)};
        case (cur.src)
            SRC_RET_HI: mem_wdata = ret_q[PC_W-1:BYTE_W];
            SRC_RET_LO: mem_wdata = ret_q[BYTE_W-1:0];
            SRC_STAT:   mem_wdata = st_q | FIXED_MASK;
            default:    mem_wdata = acc_q;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_FIN);

endmodule

// File: rtl/stack_seq_chk.sv
// Protocol checker for the stack sequencer, bound to every instance.
// Watches the memory port, SP movement and the done pulse.
module stack_seq_chk #(
    parameter logic [7:0] PAGE = 8'h01
)(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [7:0]  sp
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r12_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr[15:8] == PAGE));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re));

    a_r9_push_writes_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[7:0] == sp));

    a_r9_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - 8'd1));

    a_r9_pull_reads_above: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(mem_addr[7:0])));

endmodule

bind stack_seq stack_seq_chk #(.PAGE(PAGE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp       (sp)
);

// File: tb/test_stack_seq.sv
module test_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] pc_in = '0, target_in = '0;
    logic [7:0]  status_in = '0, acc_in = '0, x_in = '0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  sp;
    logic        busy, done;
    logic [15:0] pc_out;
    logic [7:0]  status_out, acc_out, x_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit page_bad = 0;

    logic [7:0] ram [256];
    logic [7:0] mdl [256];
    logic [7:0] sp_m, acc_m, x_m;

    always #2 clk = ~clk;

    stack_seq i_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
        .target_in(target_in), .status_in(status_in), .acc_in(acc_in),
        .x_in(x_in), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .busy(busy),
        .done(done), .pc_out(pc_out), .status_out(status_out),
        .acc_out(acc_out), .x_out(x_out)
    );

    function automatic logic [7:0] seed_byte(input int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    // Synchronous stack memory with one cycle of read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= seed_byte(i);
        end else begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
            if ((mem_we || mem_re) && mem_addr[15:8] != 8'h01) page_bad <= 1'b1;
        end
    end

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd6: return "R5";
            4'd5: return "R6";
            4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            default: return "R13";
        endcase
    endfunction

    function automatic int exp_lat(input logic [3:0] o);
        case (o)
            4'd0: return 3;
            4'd1, 4'd2: return 4;
            4'd3: return 5;
            4'd5, 4'd7: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [7:0] nz(input logic [7:0] st, input logic [7:0] v);
        logic [7:0] r;
        r = st; r[7] = v[7]; r[1] = (v == 8'd0);
        return r;
    endfunction

    function automatic logic [7:0] fix(input logic [7:0] p, input logic [7:0] c);
        return {p[7:6], c[5:4], p[3:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mpush(input logic [7:0] v);
        mdl[sp_m] = v; sp_m = sp_m - 8'd1;
    endtask

    task automatic mpull(output logic [7:0] v);
        sp_m = sp_m + 8'd1; v = mdl[sp_m];
    endtask

    // Compute the expected results of one command from the requirements.
    task automatic model(input logic [3:0] o, input logic [15:0] pc, input logic [15:0] tg,
                         input logic [7:0] st, input logic [7:0] a, input logic [7:0] x,
                         output logic [15:0] pc_e, output logic [7:0] st_e);
        logic [15:0] r;
        logic [7:0] lo, hi, s;
        r = pc + 16'd2; pc_e = pc; st_e = st;
        case (o)
            4'd0: begin mpush(r[15:8]); mpush(r[7:0]); pc_e = tg; end
            4'd1: begin mpull(lo); mpull(hi); pc_e = {hi, lo} + 16'd1; end
            4'd2: begin mpush(r[15:8]); mpush(r[7:0]); mpush(st | 8'h30); pc_e = tg; end
            4'd3: begin mpull(s); mpull(lo); mpull(hi); pc_e = {hi, lo}; st_e = fix(s, st); end
            4'd4: mpush(a);
            4'd5: begin mpull(s); acc_m = s; st_e = nz(st, s); end
            4'd6: mpush(st | 8'h30);
            4'd7: begin mpull(s); st_e = fix(s, st); end
            4'd8: sp_m = x;
            4'd9: begin x_m = sp_m; st_e = nz(st, sp_m); end
            default: ;
        endcase
    endtask

    // Issue one command; hold_cmd keeps start high with another code while busy.
    task automatic run_op(input logic [3:0] o, input logic [15:0] pc, input logic [15:0] tg,
                          input logic [7:0] st, input logic [7:0] a, input logic [7:0] x,
                          input bit hold_cmd);
        logic [15:0] pc_e;
        logic [7:0] st_e;
        int n;
        bit mem_ok;
        string rq;
        rq = req_of(o);
        model(o, pc, tg, st, a, x, pc_e, st_e);
        @(negedge clk);
        start = 1'b1; op = o; pc_in = pc; target_in = tg;
        status_in = st; acc_in = a; x_in = x;
        n = 0;
        @(negedge clk);
        if (hold_cmd) op = 4'd4; else start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(hold_cmd ? "R11" : "R10", "done latency", n, exp_lat(o));
        check(rq, "pc_out", pc_out, pc_e);
        check(rq, "status_out", status_out, st_e);
        check(rq, "acc_out", acc_out, acc_m);
        check(rq, "x_out", x_out, x_m);
        check(hold_cmd ? "R11" : rq, "sp", sp, sp_m);
        mem_ok = 1;
        for (int i = 0; i < 256; i++) if (ram[i] !== mdl[i]) mem_ok = 0;
        check(hold_cmd ? "R11" : rq, "stack memory match", mem_ok, 1);
        @(negedge clk);
        check("R10", "done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < 256; i++) mdl[i] = seed_byte(i);
        sp_m = 8'hFF; acc_m = 8'h00; x_m = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "reset sp", sp, 8'hFF);
        check("R10", "reset busy/done", {busy, done}, 2'b00);
        check("R10", "reset pc_out", pc_out, 16'h0000);
        check("R10", "reset status/acc/x", {status_out, acc_out, x_out}, 24'h0);

        // R1, R2: call saves pc+2, return adds 1 -> 0x1237
        run_op(4'd0, 16'h1234, 16'h4000, 8'hC3, 8'h00, 8'h00, 0);
        run_op(4'd1, 16'h4000, 16'h0000, 8'hC3, 8'h00, 8'h00, 0);
        check("R2", "call/return round trip", pc_out, 16'h1237);
        // R3, R4: break then interrupt return -> pc+2, fixed bits from current
        run_op(4'd2, 16'h8000, 16'hFFFE, 8'h00, 8'h00, 8'h00, 0);
        run_op(4'd3, 16'hFFFE, 16'h0000, 8'hFF, 8'h00, 8'h00, 0);
        check("R4", "break/rti pc", pc_out, 16'h8002);
        check("R4", "rti status fixed bits", status_out, 8'h30);
        // R9: wrap on push at 0x00 and pull at 0xFF
        run_op(4'd8, 16'h0100, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        run_op(4'd4, 16'h0101, 16'h0, 8'h00, 8'hA5, 8'h00, 0);
        check("R9", "push wrap sp", sp, 8'hFF);
        check("R9", "push wrap byte at 0x0100", ram[0], 8'hA5);
        run_op(4'd8, 16'h0102, 16'h0, 8'h00, 8'h00, 8'hFF, 0);
        run_op(4'd5, 16'h0103, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        check("R9", "pull wrap value", acc_out, 8'hA5);
        check("R9", "pull wrap sp", sp, 8'h00);
        // R6: zero and negative pulls
        run_op(4'd4, 16'h0200, 16'h0, 8'h80, 8'h00, 8'h00, 0);
        run_op(4'd5, 16'h0201, 16'h0, 8'h80, 8'h00, 8'h00, 0);
        check("R6", "zero pull status", status_out, 8'h02);
        run_op(4'd4, 16'h0202, 16'h0, 8'h02, 8'h91, 8'h00, 0);
        run_op(4'd5, 16'h0203, 16'h0, 8'h02, 8'h00, 8'h00, 0);
        check("R6", "negative pull status", status_out, 8'h80);
        // R5, R7: status push forces fixed bits, pull keeps current ones
        run_op(4'd6, 16'h0300, 16'h0, 8'h4C, 8'h00, 8'h00, 0);
        run_op(4'd7, 16'h0301, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        check("R7", "status round trip", status_out, 8'h4C);
        // R8: SP to X
        run_op(4'd8, 16'h0400, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        run_op(4'd9, 16'h0401, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        check("R8", "sp to x zero flag", {x_out, status_out}, 16'h0002);
        // R11: start held high during a call
        run_op(4'd0, 16'h5555, 16'h6000, 8'h11, 8'h77, 8'h00, 1);
        run_op(4'd9, 16'h0500, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        check("R11", "no extra push after held start", x_out, 8'hFE);
        // R13: unused codes
        run_op(4'd12, 16'hABCD, 16'h1111, 8'h5A, 8'h00, 8'h00, 0);
        run_op(4'd15, 16'h0F0F, 16'h2222, 8'hA5, 8'h00, 8'h00, 0);

        // Random mix
        for (int k = 0; k < 500; k++) begin
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                   8'($urandom), 8'($urandom), 8'($urandom), 0);
        end

        check("R12", "accesses stay in stack page", page_bad, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule